// File: doc/BRIEF.md
# Transmit DMA Channel Controller

This block is the control and status front end for eight transmit DMA channels. Each channel has one configuration register. It holds a two-bit run mode and a bit that allows the channel to raise internal DMA requests. A per-channel request line from the data path asks for a new frame. An accepted request waits in a one-deep pending slot until a shared round-robin launcher issues a one-cycle start pulse. The channel then counts as "in flight" until the data path returns a frame-end pulse for it.

Software reads one shared status word. The upper byte reports, per channel, that no frame is in flight. The next byte reports, per channel, that no accepted request is waiting. To stop a channel, software writes its configuration to zero and then waits until both of that channel's bits are set. The pause-at-end-of-frame mode stops new work without disturbing a frame that has already been accepted.

Top module: `tx_dma_chan_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0, the status word reads 0xFFFF0000, and frame_start is 0. A reset taken while work is in flight returns the block to this state.
- R2: Channel n's configuration register sits at byte address n*0x20, for n = 0..7. The status word is at 0x100 and is read-only. Any other address, including one that is not a multiple of 0x20 below 0x100, reads 0 and ignores writes.
- R3: A configuration register keeps bits 31:30 (mode) and bit 3 (request enable) as written. Every other bit reads 0.
- R4: A channel accepts a request at a clock edge when all of these hold: its mode is 10 (run), bit 3 is set, frame_req for that channel is high, and the channel is neither pending nor in flight. Its no-pending bit, status bit 16+n, is then 0 from the next cycle.
- R5: frame_start has at most one bit set, and only for a pending channel. The search starts at the channel after the one launched last (channel 0 first after reset). After a start pulse the channel stops pending and is in flight: its empty bit, status bit 24+n, is 0.
- R6: A frame_end pulse on an in-flight channel sets its empty bit from the next cycle. A frame_end pulse on a channel that is not in flight changes nothing.
- R7: In mode 00 or 11 a channel accepts nothing. A write of mode 00 or 11 that lands while the channel is pending cancels the request without a start pulse. A frame already in flight still runs until its frame_end.
- R8: In mode 01 a channel accepts nothing new. A request that is already pending is still launched, and a frame in flight runs until its frame_end.
- R9: With bit 3 clear, a channel accepts no request in any mode.
- R10: A channel's two status bits are both 1 only when it is neither pending nor in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| frame_req | input | 8 | Per-channel request for a new frame |
| frame_start | output | 8 | One-cycle launch pulse, at most one bit set |
| frame_end | input | 8 | Per-channel end-of-frame pulse from the data path |

## Verification
The hardest state to reach is a stop write that lands in the single cycle between acceptance and launch. In that cycle the request has been taken but no start pulse has been issued yet. The bench reaches it by raising a request for one cycle and driving the zero write in the very next cycle. It then checks that frame_start stays low and that both status bits return to 1. A similar same-cycle write of mode 01 shows that the pending frame still launches. Round-robin order is shown by making channel 1 the last one launched and then raising three requests at once, so that channel 6 must win over channel 0.

// File: rtl/tx_dma_chan_ctrl.sv
module tx_dma_chan_ctrl #(
  parameter int NUM_CH = 8,
  parameter int STRIDE = 32,
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 9'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] frame_req,
  output logic [NUM_CH-1:0] frame_start,
  input  logic [NUM_CH-1:0] frame_end
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int STR_W = $clog2(STRIDE);
  localparam int HI_W = ADDR_W - STR_W;
  localparam logic [HI_W-1:0] CH_LIM = HI_W'(NUM_CH);
  localparam logic [1:0] M_RUN = 2'b10;
  localparam logic [1:0] M_EOF = 2'b01;

  logic [1:0]        mode_v [NUM_CH];
  logic [NUM_CH-1:0] reqen_v, pend_v, fly_v, stop_v, run_v, elig;
  logic [CH_W-1:0]   last_q, win_ch;
  logic [31:0]       status_w;
  logic              unused_wdata;

  wire cfg_sel = (reg_addr[STR_W-1:0] == '0) && (reg_addr[ADDR_W-1:STR_W] < CH_LIM);
  wire st_sel  = (reg_addr == STATUS_ADDR);
  wire [CH_W-1:0] sel_ch = reg_addr[STR_W +: CH_W];
  wire wr_stop = (reg_wdata[31:30] != M_RUN) && (reg_wdata[31:30] != M_EOF);

  assign unused_wdata = ^{reg_wdata[29:4], reg_wdata[2:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0] mode;
    logic       reqen, pend, fly;
    wire wr_me = reg_wr && cfg_sel && (sel_ch == CH_W'(c));
    wire kill  = wr_me && wr_stop;
    wire stop  = (mode != M_RUN) && (mode != M_EOF);
    wire take  = (mode == M_RUN) && reqen && frame_req[c] && !pend && !fly;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode  <= 2'b00;
        reqen <= 1'b0;
        pend  <= 1'b0;
        fly   <= 1'b0;
      end else begin
        if (wr_me) begin
          mode  <= reg_wdata[31:30];
          reqen <= reg_wdata[3];
        end
        if (frame_start[c])    pend <= 1'b0;
        else if (kill || stop) pend <= 1'b0;
        else if (take)         pend <= 1'b1;
        if (frame_start[c])    fly <= 1'b1;
        else if (frame_end[c]) fly <= 1'b0;
      end
    end

    assign mode_v[c]  = mode;
    assign reqen_v[c] = reqen;
    assign pend_v[c]  = pend;
    assign fly_v[c]   = fly;
    assign stop_v[c]  = stop;
    assign run_v[c]   = (mode == M_RUN);
    assign elig[c]    = pend && !stop && !kill;
  end

  always_comb begin
    logic hit;
    logic [CH_W-1:0] idx;
    hit = 1'b0;
    win_ch = last_q;
    frame_start = '0;
    for (int i = 1; i <= NUM_CH; i++) begin
      idx = CH_W'((int'(last_q) + i) % NUM_CH);
      if (!hit && elig[idx]) begin
        hit = 1'b1;
        win_ch = idx;
        frame_start[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            last_q <= CH_W'(NUM_CH - 1);
    else if (|frame_start) last_q <= win_ch;
  end

  always_comb begin
    status_w = '0;
    status_w[24 +: NUM_CH] = ~fly_v;
    status_w[16 +: NUM_CH] = ~pend_v;
  end

  assign reg_rdata = st_sel  ? status_w :
                     cfg_sel ? {mode_v[sel_ch], 26'b0, reqen_v[sel_ch], 3'b0} :
                               32'b0;
endmodule

// File: rtl/tx_dma_chan_ctrl_chk.sv
module tx_dma_chan_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] frame_req,
  input logic [NUM_CH-1:0] frame_start,
  input logic [NUM_CH-1:0] frame_end,
  input logic [NUM_CH-1:0] pend_v,
  input logic [NUM_CH-1:0] fly_v,
  input logic [NUM_CH-1:0] stop_v,
  input logic [NUM_CH-1:0] run_v,
  input logic [NUM_CH-1:0] reqen_v
);
  a_r5_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(frame_start));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    a_r5_launch_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start[c] |-> pend_v[c]);
    a_r5_launch_to_fly: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start[c] |=> (fly_v[c] && !pend_v[c]));
    a_r6_end_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (fly_v[c] && frame_end[c]) |=> !fly_v[c]);
    a_r7_stop_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
      stop_v[c] |-> !frame_start[c]);
    a_r4_accept_rule: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_v[c]) |-> $past(run_v[c] && reqen_v[c] && frame_req[c] && !fly_v[c]));
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_v[c] && fly_v[c]));
  end
endmodule

bind tx_dma_chan_ctrl tx_dma_chan_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_start(frame_start),
  .frame_end(frame_end), .pend_v(pend_v), .fly_v(fly_v), .stop_v(stop_v),
  .run_v(run_v), .reqen_v(reqen_v)
);

// File: tb/test_tx_dma_chan_ctrl.sv
`timescale 1ns/1ps
module test_tx_dma_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  frame_req = '0, frame_start, frame_end = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  tx_dma_chan_ctrl i_tx_dma_chan_ctrl (.*);

  always #2.5 clk = ~clk;

  // {write, addr, wdata, expected readback}
  localparam logic [73:0] VEC [12] = '{
    {1'b1, 9'h000, 32'hFFFFFFFF, 32'hC0000008},
    {1'b1, 9'h020, 32'h80000008, 32'h80000008},
    {1'b1, 9'h0E0, 32'h4000FFF7, 32'h40000000},
    {1'b1, 9'h024, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 9'h100, 32'h12345678, 32'hFFFF0000},
    {1'b1, 9'h120, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 9'h0C0, 32'h00000008, 32'h00000008},
    {1'b0, 9'h000, 32'h00000000, 32'hC0000008},
    {1'b1, 9'h020, 32'h00000000, 32'h00000000},
    {1'b1, 9'h000, 32'h00000000, 32'h00000000},
    {1'b1, 9'h0E0, 32'h00000000, 32'h00000000},
    {1'b1, 9'h0C0, 32'h00000000, 32'h00000000}
  };

  function automatic logic [31:0] st(logic [7:0] fly, logic [7:0] pend);
    return {~fly, ~pend, 16'h0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_st(string tag, logic [7:0] fly, logic [7:0] pend);
    logic [31:0] d;
    rd(9'h100, d);
    chk(tag, d, st(fly, pend));
  endtask

  task automatic pulse_req(logic [7:0] m);
    frame_req = m; tick(); frame_req = '0;
  endtask

  task automatic pulse_end(logic [7:0] m);
    frame_end = m; tick(); frame_end = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_st("R1 status after reset", 8'h00, 8'h00);
    rd(9'h000, d); chk("R1 cfg0 after reset", d, 32'h0);
    chk("R1 frame_start after reset", {24'h0, frame_start}, 32'h0);

    // R2/R3 table walk
    foreach (VEC[k]) begin
      if (VEC[k][73]) wr(VEC[k][72:64], VEC[k][63:32]);
      rd(VEC[k][72:64], d);
      chk($sformatf("R2/R3 vector %0d", k), d, VEC[k][31:0]);
    end

    // R4 R5 R6 single channel lifecycle
    wr(9'h040, 32'h80000008);
    pulse_req(8'h04);
    #1 chk("R5 start pulse ch2", {24'h0, frame_start}, 32'h04);
    chk_st("R4 ch2 pending", 8'h00, 8'h04);
    tick();
    #1 chk("R5 no second pulse", {24'h0, frame_start}, 32'h0);
    chk_st("R5 ch2 in flight", 8'h04, 8'h00);
    pulse_end(8'h20);
    chk_st("R6 stray frame_end ignored", 8'h04, 8'h00);
    pulse_end(8'h04);
    chk_st("R6 R10 ch2 drained", 8'h00, 8'h00);

    // R5 round-robin rotation
    wr(9'h000, 32'h80000008);
    wr(9'h020, 32'h80000008);
    wr(9'h0C0, 32'h80000008);
    pulse_req(8'h02);
    #1 chk("R5 ch1 alone", {24'h0, frame_start}, 32'h02);
    tick();
    pulse_end(8'h02);
    pulse_req(8'h43);
    #1 chk("R5 rr first ch6", {24'h0, frame_start}, 32'h40);
    tick();
    #1 chk("R5 rr second ch0", {24'h0, frame_start}, 32'h01);
    tick();
    #1 chk("R5 rr third ch1", {24'h0, frame_start}, 32'h02);
    tick();
    #1 chk("R5 rr done", {24'h0, frame_start}, 32'h0);
    chk_st("R5 three in flight", 8'h43, 8'h00);
    pulse_end(8'h43);
    chk_st("R6 all drained", 8'h00, 8'h00);

    // R7 stop write in the pending cycle
    wr(9'h060, 32'h80000008);
    pulse_req(8'h08);
    reg_wr = 1'b1; reg_addr = 9'h060; reg_wdata = 32'h0;
    #1 chk("R7 launch masked by stop write", {24'h0, frame_start}, 32'h0);
    tick();
    reg_wr = 1'b0;
    chk_st("R7 pending cancelled", 8'h00, 8'h00);
    rd(9'h060, d); chk("R7 cfg3 cleared", d, 32'h0);
    tick();
    #1 chk("R7 no late launch", {24'h0, frame_start}, 32'h0);

    // R7 mode 11 behaves as stop
    wr(9'h060, 32'hC0000008);
    pulse_req(8'h08);
    #1 chk("R7 mode 11 no start", {24'h0, frame_start}, 32'h0);
    chk_st("R7 mode 11 no accept", 8'h00, 8'h00);

    // R7 R10 in-flight frame under stop
    wr(9'h060, 32'h80000008);
    pulse_req(8'h08);
    tick();
    wr(9'h060, 32'h0);
    chk_st("R10 stop waits for frame_end", 8'h08, 8'h00);
    pulse_end(8'h08);
    chk_st("R10 idle after drain", 8'h00, 8'h00);

    // R8 pause at end of frame
    wr(9'h0A0, 32'h80000008);
    pulse_req(8'h20);
    reg_wr = 1'b1; reg_addr = 9'h0A0; reg_wdata = 32'h40000008;
    #1 chk("R8 pending still launches", {24'h0, frame_start}, 32'h20);
    tick();
    reg_wr = 1'b0;
    chk_st("R8 frame runs on", 8'h20, 8'h00);
    pulse_end(8'h20);
    chk_st("R8 stopped after end", 8'h00, 8'h00);
    pulse_req(8'h20);
    chk_st("R8 no new accept", 8'h00, 8'h00);
    tick();
    #1 chk("R8 no start", {24'h0, frame_start}, 32'h0);

    // R9 request enable clear
    wr(9'h0E0, 32'h80000000);
    pulse_req(8'h80);
    chk_st("R9 no accept without enable", 8'h00, 8'h00);
    tick();
    #1 chk("R9 no start", {24'h0, frame_start}, 32'h0);

    // R1 reset mid-operation
    wr(9'h040, 32'h80000008);
    pulse_req(8'h04);
    tick();
    rst_n = 1'b0;
    #1 chk_st("R1 reset clears flight", 8'h00, 8'h00);
    rd(9'h040, d); chk("R1 reset clears cfg", d, 32'h0);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule